// File: doc/BRIEF.md
# Ordered Write-Buffer Issue Arbiter

This block holds a small pool of buffered writes and decides, every cycle, whether the next request sent to the lower memory level comes from the miss queue or from the write pool. It hands out sequence numbers from one shared counter to every new miss and every new write. A buffered write may not overtake an older miss that touches any of the same bytes. While such a conflict exists, misses go out oldest first until it clears.

Writes arrive on a valid/ready port. A write enters the local pool when it is uncacheable, when the write-allocate enable is low, or when it needs no response. Any other accepted write is flagged back as a miss-queue allocation and takes an order number. The miss queue itself stays outside. It presents its pending (not yet in service) entries as flat vectors of address, size and order. It reports its own new allocations on a single pulse and takes the order number the block offers. The issue port is valid/ready. A transfer marks the chosen entry as in service. For a miss, the miss queue must clear that entry's pending bit itself.

Back-pressure rules: `wa_ready` is low exactly while every pool slot is occupied, whatever the write's attributes. A write is taken on a cycle where `wa_valid` and `wa_ready` are both high. `iss_valid` does not wait for `iss_ready`. The offered entry may change from cycle to cycle while `iss_ready` is low.

Top module: `wbuf_issue_arb`

## Requirements
- R1: A shared counter starts at 0 after reset. `ord_miss` shows the current value. `ord_wr` shows that value plus 1 when `mq_new` is high, and the value itself otherwise. The counter advances by `mq_new` plus one for an accepted write. All values are modulo 2^ORD_W.
- R2: An accepted write goes into the pool when `wa_uncache`, `wa_noresp` or not `wr_alloc_en` holds. Otherwise `wa_to_mq` pulses in the accept cycle and the pool is unchanged.
- R3: A miss [ms, ms+mz) and a write [ws, ws+wz) overlap if ms < ws and ms+mz > ws, or else if ws+wz > ms. Ranges that only touch at a boundary do not overlap.
- R4: If the head write overlaps a pending miss whose order is older, the issue port offers the oldest pending miss (`iss_src`=0).
- R5: With no conflict, the head write is offered (`iss_src`=1) when the pool is full. Otherwise the oldest pending miss is offered, and the head write only when no miss is pending. `iss_valid` is low when neither side has an entry.
- R6: Order a is older than b when bit ORD_W-1 of (a-b) mod 2^ORD_W is set, so priority holds across counter wrap.
- R7: `wb_blocked` is high exactly while all slots are occupied, and it drops on the cycle after a slot is freed. `wa_ready` is its inverse.
- R8: `wb_busreq` is high exactly while some pooled write is not yet in service.
- R9: A write that needs no response is freed when it is issued. Other writes are freed by `cmp_valid` with `cmp_idx` naming their slot (the `iss_idx` given at issue). A completion naming a free or not-yet-issued slot is ignored.
- R10: The head write is the pending pooled write with the oldest order. A new write takes the lowest-numbered free slot. `iss_idx`, `iss_addr` and `iss_size` describe the offered entry.
- R11: After reset the pool is empty, `wa_ready` is 1, and `iss_valid`, `wb_busreq`, `wb_blocked` and both order outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_alloc_en | input | 1 | Write-allocate enable |
| mq_new | input | 1 | Miss queue allocates a miss this cycle |
| ord_miss | output | ORD_W | Order number for that miss |
| wa_valid | input | 1 | Write request valid |
| wa_ready | output | 1 | Write request accepted |
| wa_addr | input | ADDR_W | Write start byte address |
| wa_size | input | SZ_W | Write length in bytes |
| wa_uncache | input | 1 | Write is uncacheable |
| wa_noresp | input | 1 | Write needs no response |
| wa_to_mq | output | 1 | Accepted write belongs in the miss queue |
| ord_wr | output | ORD_W | Order number for the accepted write |
| mq_pend | input | MQ_N | Per-entry pending flags of the miss queue |
| mq_addr | input | MQ_N*ADDR_W | Packed miss start addresses |
| mq_size | input | MQ_N*SZ_W | Packed miss lengths |
| mq_ord | input | MQ_N*ORD_W | Packed miss order numbers |
| iss_valid | output | 1 | Issue offer valid |
| iss_ready | input | 1 | Lower level takes the offer (marks in service) |
| iss_src | output | 1 | 0 miss queue, 1 write pool |
| iss_idx | output | IDX_W | Entry or slot index of the offer |
| iss_addr | output | ADDR_W | Offered start address |
| iss_size | output | SZ_W | Offered length |
| cmp_valid | input | 1 | Write completion response |
| cmp_idx | input | WB_IX_W | Slot completed |
| wb_busreq | output | 1 | Write side requests the bus |
| wb_blocked | output | 1 | No free write slot |

## Verification
Two pairs of functions can fall on the same clock edge. In the first, a new miss and an accepted write both take order numbers. In the second, one slot is freed, by a completion or by issuing a no-response write, while another slot is allocated or marked in service. A directed step drives `mq_new` together with a pooled write. A long random phase drives completions, issues and writes on every cycle with slot indices chosen at random. A queue-based reference model in the bench predicts the ready, blocked, bus-request, order and issue outputs on every clock. The directed full-pool cases place a miss one byte short of, and one byte into, the head write, including just after counter wrap. The model decides which source must be chosen in each case.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;
  typedef enum logic {SRC_MISS = 1'b0, SRC_WRITE = 1'b1} src_e;

  // a older than b under modulo-2^w ordering
  function automatic logic seq_before(input logic [31:0] a, input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  // byte-range intersection of miss [ms,ms+mz) and write [ws,ws+wz)
  function automatic logic range_hit(input logic [32:0] ms, input logic [32:0] mz,
                                     input logic [32:0] ws, input logic [32:0] wz);
    if (ms < ws) return (ms + mz) > ws;
    else         return (ws + wz) > ms;
  endfunction
endpackage

// File: rtl/wbarb_ord.sv
module wbarb_ord #(
  parameter int ORD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_new,
  input  logic             wr_new,
  output logic [ORD_W-1:0] ord_miss,
  output logic [ORD_W-1:0] ord_wr
);
  logic [ORD_W-1:0] cnt;

  assign ord_miss = cnt;
  assign ord_wr   = cnt + ORD_W'(miss_new);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + ORD_W'(miss_new) + ORD_W'(wr_new);
  end

  AST_ORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_new && !wr_new) |=> $stable(ord_miss)); // R1
  AST_ORD_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_new && wr_new) |-> (ord_wr != ord_miss)); // R1
endmodule

// File: rtl/wbarb_wbuf.sv
module wbarb_wbuf
  import wbarb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5,
  parameter int ORD_W  = 6,
  parameter int DEPTH  = 4,
  localparam int IX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [SZ_W-1:0]   alloc_size,
  input  logic [ORD_W-1:0]  alloc_ord,
  input  logic              alloc_nrs,
  input  logic              issue,
  input  logic              cmp_valid,
  input  logic [IX_W-1:0]   cmp_idx,
  output logic              full,
  output logic              head_valid,
  output logic [IX_W-1:0]   head_idx,
  output logic [ADDR_W-1:0] head_addr,
  output logic [SZ_W-1:0]   head_size,
  output logic [ORD_W-1:0]  head_ord
);
  logic              vld [DEPTH];
  logic              svc [DEPTH];
  logic              nrs [DEPTH];
  logic [ADDR_W-1:0] adr [DEPTH];
  logic [SZ_W-1:0]   siz [DEPTH];
  logic [ORD_W-1:0]  ord [DEPTH];
  logic [IX_W-1:0]   free_idx;

  always_comb begin
    logic found;
    found    = 1'b0;
    free_idx = '0;
    full     = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i]) full = 1'b0;
      if (!vld[i] && !found) begin
        free_idx = IX_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    logic [ORD_W-1:0] best;
    best       = '0;
    head_valid = 1'b0;
    head_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !svc[i] &&
          (!head_valid || seq_before(32'(ord[i]), 32'(best), ORD_W))) begin
        head_valid = 1'b1;
        head_idx   = IX_W'(i);
        best       = ord[i];
      end
    end
    head_addr = adr[head_idx];
    head_size = siz[head_idx];
    head_ord  = best;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        svc[g] <= 1'b0;
      end else if (alloc && free_idx == IX_W'(g)) begin
        vld[g] <= 1'b1;
        svc[g] <= 1'b0;
      end else if (issue && head_idx == IX_W'(g)) begin
        if (nrs[g]) vld[g] <= 1'b0;
        else        svc[g] <= 1'b1;
      end else if (cmp_valid && cmp_idx == IX_W'(g) && vld[g] && svc[g]) begin
        vld[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc && free_idx == IX_W'(g)) begin
        adr[g] <= alloc_addr;
        siz[g] <= alloc_size;
        ord[g] <= alloc_ord;
        nrs[g] <= alloc_nrs;
      end
    end
  end

  AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full); // R7
  AST_NORESP_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && head_valid && nrs[head_idx]) |=> !vld[$past(head_idx)]); // R9
  AST_CMP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && vld[cmp_idx] && svc[cmp_idx]) |=> !vld[$past(cmp_idx)]); // R9
endmodule

// File: rtl/wbarb_mpick.sv
module wbarb_mpick
  import wbarb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5,
  parameter int ORD_W  = 6,
  parameter int N      = 4,
  localparam int IX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        pend,
  input  logic [N*ADDR_W-1:0] addr,
  input  logic [N*SZ_W-1:0]   size,
  input  logic [N*ORD_W-1:0]  ord,
  input  logic                hw_valid,
  input  logic [ADDR_W-1:0]   hw_addr,
  input  logic [SZ_W-1:0]     hw_size,
  input  logic [ORD_W-1:0]    hw_ord,
  output logic                any,
  output logic [IX_W-1:0]     idx,
  output logic                conflict
);
  always_comb begin
    logic [ORD_W-1:0] best;
    best     = '0;
    any      = 1'b0;
    idx      = '0;
    conflict = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) begin
        if (!any || seq_before(32'(ord[i*ORD_W +: ORD_W]), 32'(best), ORD_W)) begin
          any  = 1'b1;
          idx  = IX_W'(i);
          best = ord[i*ORD_W +: ORD_W];
        end
        if (hw_valid &&
            seq_before(32'(ord[i*ORD_W +: ORD_W]), 32'(hw_ord), ORD_W) &&
            range_hit(33'(addr[i*ADDR_W +: ADDR_W]), 33'(size[i*SZ_W +: SZ_W]),
                      33'(hw_addr), 33'(hw_size)))
          conflict = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbuf_issue_arb.sv
module wbuf_issue_arb
  import wbarb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5,
  parameter int ORD_W  = 6,
  parameter int WB_N   = 4,
  parameter int MQ_N   = 4,
  localparam int WB_IX_W = (WB_N > 1) ? $clog2(WB_N) : 1,
  localparam int MQ_IX_W = (MQ_N > 1) ? $clog2(MQ_N) : 1,
  localparam int IDX_W   = (WB_IX_W > MQ_IX_W) ? WB_IX_W : MQ_IX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_alloc_en,
  input  logic                   mq_new,
  output logic [ORD_W-1:0]       ord_miss,
  input  logic                   wa_valid,
  output logic                   wa_ready,
  input  logic [ADDR_W-1:0]      wa_addr,
  input  logic [SZ_W-1:0]        wa_size,
  input  logic                   wa_uncache,
  input  logic                   wa_noresp,
  output logic                   wa_to_mq,
  output logic [ORD_W-1:0]       ord_wr,
  input  logic [MQ_N-1:0]        mq_pend,
  input  logic [MQ_N*ADDR_W-1:0] mq_addr,
  input  logic [MQ_N*SZ_W-1:0]   mq_size,
  input  logic [MQ_N*ORD_W-1:0]  mq_ord,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic                   iss_src,
  output logic [IDX_W-1:0]       iss_idx,
  output logic [ADDR_W-1:0]      iss_addr,
  output logic [SZ_W-1:0]        iss_size,
  input  logic                   cmp_valid,
  input  logic [WB_IX_W-1:0]     cmp_idx,
  output logic                   wb_busreq,
  output logic                   wb_blocked
);
  logic               full, hw_valid, m_any, conflict, pick_wr;
  logic               wa_fire, to_pool, wb_issue;
  logic [WB_IX_W-1:0] hw_idx;
  logic [ADDR_W-1:0]  hw_addr;
  logic [SZ_W-1:0]    hw_size;
  logic [ORD_W-1:0]   hw_ord;
  logic [MQ_IX_W-1:0] m_idx;
  src_e               src;

  assign wa_ready = !full;
  assign wa_fire  = wa_valid && wa_ready;
  assign to_pool  = wa_uncache || wa_noresp || !wr_alloc_en;
  assign wa_to_mq = wa_fire && !to_pool;

  wbarb_ord #(.ORD_W(ORD_W)) u_ord (
    .clk(clk), .rst_n(rst_n), .miss_new(mq_new), .wr_new(wa_fire),
    .ord_miss(ord_miss), .ord_wr(ord_wr));

  wbarb_wbuf #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .ORD_W(ORD_W), .DEPTH(WB_N)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .alloc(wa_fire && to_pool), .alloc_addr(wa_addr), .alloc_size(wa_size),
    .alloc_ord(ord_wr), .alloc_nrs(wa_noresp),
    .issue(wb_issue), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .full(full), .head_valid(hw_valid), .head_idx(hw_idx),
    .head_addr(hw_addr), .head_size(hw_size), .head_ord(hw_ord));

  wbarb_mpick #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .ORD_W(ORD_W), .N(MQ_N)) u_mpick (
    .pend(mq_pend), .addr(mq_addr), .size(mq_size), .ord(mq_ord),
    .hw_valid(hw_valid), .hw_addr(hw_addr), .hw_size(hw_size), .hw_ord(hw_ord),
    .any(m_any), .idx(m_idx), .conflict(conflict));

  always_comb begin
    pick_wr  = hw_valid && !conflict && (full || !m_any);
    src      = pick_wr ? SRC_WRITE : SRC_MISS;
    iss_src  = src;
    iss_valid = m_any || hw_valid;
    iss_idx  = pick_wr ? IDX_W'(hw_idx) : IDX_W'(m_idx);
    iss_addr = pick_wr ? hw_addr : mq_addr[m_idx*ADDR_W +: ADDR_W];
    iss_size = pick_wr ? hw_size : mq_size[m_idx*SZ_W +: SZ_W];
  end

  assign wb_issue   = iss_valid && iss_ready && pick_wr;
  assign wb_busreq  = hw_valid;
  assign wb_blocked = full;

  AST_CONFLICT_MISS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (iss_valid && iss_src == SRC_MISS)); // R4
  AST_FULL_PREFERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_blocked && wb_busreq && !conflict) |-> (iss_src == SRC_WRITE)); // R5
  AST_BUSREQ_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busreq |-> iss_valid); // R8
  AST_MQ_ROUTE_KEEPS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_to_mq && !wb_issue && !cmp_valid) |=> $stable(wb_blocked)); // R2
endmodule

// File: tb/wbuf_issue_arb_test.sv
`timescale 1ns/1ps
module wbuf_issue_arb_test;
  localparam int AW = 16, ZW = 5, OW = 6, WN = 4, MN = 4;
  localparam int OM = (1 << OW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic wr_alloc_en = 1'b1, mq_new = 1'b0, wa_valid = 1'b0, wa_uncache = 1'b0;
  logic wa_noresp = 1'b0, iss_ready = 1'b0, cmp_valid = 1'b0;
  logic [AW-1:0] wa_addr = '0;
  logic [ZW-1:0] wa_size = '0;
  logic [1:0]    cmp_idx = '0;
  logic          p_pend [MN];
  logic [AW-1:0] p_addr [MN];
  logic [ZW-1:0] p_size [MN];
  logic [OW-1:0] p_ord  [MN];
  logic [MN-1:0]    mq_pend;
  logic [MN*AW-1:0] mq_addr;
  logic [MN*ZW-1:0] mq_size;
  logic [MN*OW-1:0] mq_ord;
  logic [OW-1:0] ord_miss, ord_wr;
  logic wa_ready, wa_to_mq, iss_valid, iss_src, wb_busreq, wb_blocked;
  logic [1:0] iss_idx;
  logic [AW-1:0] iss_addr;
  logic [ZW-1:0] iss_size;

  always_comb
    for (int i = 0; i < MN; i++) begin
      mq_pend[i] = p_pend[i];
      mq_addr[i*AW +: AW] = p_addr[i];
      mq_size[i*ZW +: ZW] = p_size[i];
      mq_ord[i*OW +: OW]  = p_ord[i];
    end

  wbuf_issue_arb uut (
    .clk(clk), .rst_n(rst_n), .wr_alloc_en(wr_alloc_en), .mq_new(mq_new),
    .ord_miss(ord_miss), .wa_valid(wa_valid), .wa_ready(wa_ready),
    .wa_addr(wa_addr), .wa_size(wa_size), .wa_uncache(wa_uncache),
    .wa_noresp(wa_noresp), .wa_to_mq(wa_to_mq), .ord_wr(ord_wr),
    .mq_pend(mq_pend), .mq_addr(mq_addr), .mq_size(mq_size), .mq_ord(mq_ord),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_src(iss_src),
    .iss_idx(iss_idx), .iss_addr(iss_addr), .iss_size(iss_size),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .wb_busreq(wb_busreq),
    .wb_blocked(wb_blocked));

  int total = 0, bad = 0;
  // reference model state
  bit mv [WN], ms [WN], mn [WN];
  int ma [WN], mz [WN], mo [WN];
  int cnt = 0;
  bit e_full, e_hv, e_many, e_conf, e_pw, e_iv;
  int e_free, e_hi, e_mi;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic bit older(input int a, input int b);
    return ((a - b) & OM) >= (1 << (OW - 1));
  endfunction

  function automatic bit hit(input int s1, input int z1, input int s2, input int z2);
    if (s1 < s2) return s1 + z1 > s2;
    return s2 + z2 > s1;
  endfunction

  task automatic model_eval();
    e_full = 1; e_free = -1; e_hv = 0; e_hi = 0; e_many = 0; e_mi = 0; e_conf = 0;
    for (int i = 0; i < WN; i++) begin
      if (!mv[i]) begin e_full = 0; if (e_free < 0) e_free = i; end
      if (mv[i] && !ms[i] && (!e_hv || older(mo[i], mo[e_hi]))) begin e_hv = 1; e_hi = i; end
    end
    for (int i = 0; i < MN; i++)
      if (p_pend[i]) begin
        if (!e_many || older(int'(p_ord[i]), int'(p_ord[e_mi]))) begin e_many = 1; e_mi = i; end
        if (e_hv && older(int'(p_ord[i]), mo[e_hi]) &&
            hit(int'(p_addr[i]), int'(p_size[i]), ma[e_hi], mz[e_hi])) e_conf = 1;
      end
    e_pw = e_hv && !e_conf && (e_full || !e_many);
    e_iv = e_hv || e_many;
  endtask

  task automatic compare();
    bit tobuf;
    tobuf = wa_uncache || wa_noresp || !wr_alloc_en;
    chk("R7 wa_ready", 32'(wa_ready), 32'(!e_full));
    chk("R7 wb_blocked", 32'(wb_blocked), 32'(e_full));
    chk("R8 wb_busreq", 32'(wb_busreq), 32'(e_hv));
    chk("R1 ord_miss", 32'(ord_miss), 32'(cnt & OM));
    chk("R1 ord_wr", 32'(ord_wr), 32'((cnt + int'(mq_new)) & OM));
    chk("R2 wa_to_mq", 32'(wa_to_mq), 32'(wa_valid && !e_full && !tobuf));
    chk("R5 iss_valid", 32'(iss_valid), 32'(e_iv));
    if (e_iv) begin
      chk("R4 R5 R6 iss_src", 32'(iss_src), 32'(e_pw));
      chk("R10 iss_idx", 32'(iss_idx), 32'(e_pw ? e_hi : e_mi));
      chk("R10 iss_addr", 32'(iss_addr), 32'(e_pw ? ma[e_hi] : int'(p_addr[e_mi])));
      chk("R10 iss_size", 32'(iss_size), 32'(e_pw ? mz[e_hi] : int'(p_size[e_mi])));
    end
  endtask

  task automatic model_update();
    bit fire, cok, acc;
    cok = cmp_valid && mv[cmp_idx] && ms[cmp_idx];
    fire = e_iv && iss_ready;
    if (fire && e_pw) begin
      if (mn[e_hi]) mv[e_hi] = 0; else ms[e_hi] = 1;
    end
    if (fire && !e_pw) p_pend[e_mi] = 0;   // miss queue marks its entry in service
    if (cok) mv[cmp_idx] = 0;
    acc = wa_valid && !e_full;
    if (acc && (wa_uncache || wa_noresp || !wr_alloc_en)) begin
      mv[e_free] = 1; ms[e_free] = 0; mn[e_free] = wa_noresp;
      ma[e_free] = int'(wa_addr); mz[e_free] = int'(wa_size);
      mo[e_free] = (cnt + int'(mq_new)) & OM;
    end
    cnt = cnt + int'(mq_new) + int'(acc);
  endtask

  task automatic tick();
    @(negedge clk);
    model_eval();
    compare();
    @(posedge clk);
    #0.5;
    model_update();
  endtask

  task automatic setw(input int a, input int z, input bit u, input bit n);
    wa_valid = 1; wa_addr = AW'(a); wa_size = ZW'(z); wa_uncache = u; wa_noresp = n;
  endtask

  task automatic setm(input int i, input int a, input int z, input int o);
    p_pend[i] = 1; p_addr[i] = AW'(a); p_size[i] = ZW'(z); p_ord[i] = OW'(o);
  endtask

  task automatic drain();
    wa_valid = 0; mq_new = 0;
    for (int i = 0; i < MN; i++) p_pend[i] = 0;
    iss_ready = 1;
    repeat (6) tick();
    iss_ready = 0; cmp_valid = 1;
    for (int i = 0; i < WN; i++) begin cmp_idx = 2'(i); tick(); end
    cmp_valid = 0;
  endtask

  task automatic fill4(input int base);
    for (int i = 0; i < 4; i++) begin setw(base + i * 'h100, 8, 1, 0); tick(); end
    wa_valid = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int o_old;
    for (int i = 0; i < MN; i++) begin p_pend[i] = 0; p_addr[i] = '0; p_size[i] = '0; p_ord[i] = '0; end
    for (int i = 0; i < WN; i++) begin mv[i] = 0; ms[i] = 0; mn[i] = 0; end
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 wa_ready", 32'(wa_ready), 1);
    chk("R11 iss_valid", 32'(iss_valid), 0);
    chk("R11 busreq", 32'(wb_busreq), 0);
    chk("R11 blocked", 32'(wb_blocked), 0);
    chk("R11 ord", 32'({ord_miss, ord_wr}), 0);
    @(posedge clk); #0.5;

    // R2 routing
    setw('h40, 8, 0, 0); tick();
    setw('h80, 4, 0, 1); tick();
    mq_new = 1; setw('h200, 8, 1, 0); tick();     // R1 simultaneous allocation
    mq_new = 0; wr_alloc_en = 0; setw('h300, 8, 0, 0); tick();
    wr_alloc_en = 1; wa_valid = 0;
    // R4 conflict with older miss, then in-order drain
    setm(0, 'h200, 4, 2); setm(2, 'h7C, 8, 0);
    iss_ready = 1; repeat (6) tick();
    iss_ready = 0; cmp_valid = 1;
    cmp_idx = 3; tick();            // R9 ignored completion
    cmp_idx = 1; tick(); cmp_idx = 2; tick(); cmp_valid = 0; tick();

    // R7 fill, held write, R5 full prefers write
    fill4('h900);
    setm(3, 'h2000, 4, cnt & OM); setw('h3000, 4, 1, 0);
    repeat (2) tick();
    iss_ready = 1; tick(); iss_ready = 0;
    cmp_valid = 1; cmp_idx = 0; tick(); cmp_valid = 0;
    repeat (2) tick();
    drain();

    // R3 boundaries with full pool and older miss
    o_old = cnt & OM; mq_new = 1; tick(); mq_new = 0;
    fill4('h500);
    setm(0, 'h508, 4, o_old); tick();
    setm(0, 'h4F8, 8, o_old); tick();
    setm(0, 'h4F9, 8, o_old); tick();
    setm(0, 'h507, 4, o_old); tick();
    setm(0, 'h500, 8, cnt & OM); tick();       // younger overlapping miss: no conflict
    drain();

    // R6 wrap
    mq_new = 1;
    while ((cnt & OM) != OM) tick();
    o_old = cnt & OM; tick(); mq_new = 0;
    fill4('h500);
    setm(1, 'h504, 2, o_old); tick();
    iss_ready = 1; tick(); iss_ready = 0; tick();
    drain();

    // random phase
    for (int c = 0; c < 600; c++) begin
      wa_valid = 1'($urandom); wa_addr = AW'(($urandom % 64) * 4);
      wa_size = ZW'(1 + $urandom % 16); wa_uncache = 1'($urandom);
      wa_noresp = 1'($urandom); wr_alloc_en = 1'($urandom);
      mq_new = 1'($urandom); iss_ready = ($urandom % 4) != 0;
      cmp_valid = 1'($urandom); cmp_idx = 2'($urandom);
      for (int i = 0; i < MN; i++)
        if (!p_pend[i] && ($urandom % 4) == 0)
          setm(i, ($urandom % 64) * 4, 1 + $urandom % 16, (cnt - $urandom % 8) & OM);
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule